// File: doc/BRIEF.md
# Serial Receive Clock Controller

This block derives the timing events for the receive half of a synchronous serial port. One of three clock sources is selected: the divided master clock, the transmit clock, or the receive-clock pin. Each source arrives as a pair of single-cycle rise and fall strobes in the system-clock domain. The selected clock can be gated by the level of the frame-sync input. From the gated clock edges the block produces two strobes. A sample strobe tells the receiver when to capture data and frame sync. A launch strobe marks when an outgoing frame sync is shifted out. The block also produces the drive level and the output enable for the receive-clock pin.

All settings live in an 8-bit mode register. The register accepts writes only while the write-protect input is low. The inversion bit swaps the roles of the rising and falling edges for sampling and launching. It never inverts the clock driven on the pin. The pin can be left as an input, driven continuously, or driven only around data transfers.

Top module: `rx_clk_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `mode_q` is 0x00 and `sample_stb`, `launch_stb`, `pin_oe` and `pin_drive` are all 0.
- R2: A write (`cfg_wr` high) with `wp_en` low loads `cfg_data` into `mode_q` at the next clock edge. A write with `wp_en` high leaves `mode_q` unchanged.
- R3: The source field `mode_q[1:0]` picks the edge pair: 0 selects bit 0 of `src_rise`/`src_fall` (divided clock), 1 selects bit 1 (transmit clock), and 2 selects bit 2 (pin). Value 3 selects nothing, so no strobe is produced. Edges on sources that are not selected produce no strobe.
- R4: With the inversion bit `mode_q[5]` at 0, a selected fall edge gives `sample_stb` one cycle later, and a selected rise edge gives `launch_stb` one cycle later.
- R5: With `mode_q[5]` at 1, a selected rise edge gives `sample_stb` and a selected fall edge gives `launch_stb`, each one cycle later.
- R6: The gating field `mode_q[7:6]` controls which edges pass. Value 0 passes every edge, and so does value 3. Value 1 passes edges only while `fsync` is low. Value 2 passes edges only while `fsync` is high. A blocked edge produces neither strobe and does not change the pin clock level.
- R7: With output mode `mode_q[4:2]` at 0, or at any value from 3 to 7, `pin_oe` and `pin_drive` are 0 from the next cycle on.
- R8: With output mode 1, `pin_oe` is 1 and `pin_drive` follows the gated clock level. The level goes to 1 one cycle after a passed rise edge and to 0 one cycle after a passed fall edge, whatever the inversion bit holds.
- R9: With output mode 2, `pin_oe` goes to 1 one cycle after `xfer_active` is seen high. After `xfer_active` falls, `pin_oe` stays 1 until the first passed edge, then goes to 0 one cycle after that edge. `pin_drive` is the clock level while `pin_oe` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Mode register write strobe |
| cfg_data | input | 8 | Mode register write data |
| wp_en | input | 1 | Write-protect enable; blocks writes when high |
| mode_q | output | 8 | Current mode register contents |
| src_rise | input | 3 | Rise strobes: bit 0 divided clock, bit 1 transmit clock, bit 2 pin |
| src_fall | input | 3 | Fall strobes, same bit order as `src_rise` |
| fsync | input | 1 | Frame-sync level used for gating |
| xfer_active | input | 1 | High while a data transfer is in progress |
| sample_stb | output | 1 | Capture strobe for data and frame sync |
| launch_stb | output | 1 | Frame-sync launch strobe |
| pin_oe | output | 1 | Receive-clock pin output enable |
| pin_drive | output | 1 | Level driven on the receive-clock pin |

## Verification
The hardest state to reach from the ports is transfer-only output mode with the enable still held after `xfer_active` has dropped, while the gate is blocking. There, an edge arriving under a closed gate must not release the pin, and only the next passed edge may release it. The stimulus enters this state directly. It ends a transfer, raises `fsync` under gating mode 1, sends edges that must be ignored, and then lowers `fsync` so that the next edge releases the pin. A cycle-accurate model in the bench follows every step and compares all outputs on every clock.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

    localparam int NUM_SRC = 3;
    localparam int MODE_W  = 8;

    typedef enum logic [1:0] {
        SRC_DIV  = 2'd0,
        SRC_TX   = 2'd1,
        SRC_PIN  = 2'd2,
        SRC_NONE = 2'd3
    } src_sel_e;

    typedef enum logic [2:0] {
        PIN_IN    = 3'd0,
        PIN_CONT  = 3'd1,
        PIN_XFER  = 3'd2,
        PIN_RSV3  = 3'd3,
        PIN_RSV4  = 3'd4,
        PIN_RSV5  = 3'd5,
        PIN_RSV6  = 3'd6,
        PIN_RSV7  = 3'd7
    } pin_mode_e;

    typedef enum logic [1:0] {
        GATE_OFF  = 2'd0,
        GATE_LOW  = 2'd1,
        GATE_HIGH = 2'd2,
        GATE_RSV  = 2'd3
    } gate_e;

    typedef struct packed {
        gate_e     gate;
        logic      inv;
        pin_mode_e pmode;
        src_sel_e  src;
    } mode_t;

endpackage

// File: rtl/rxc_mode_reg.sv
module rxc_mode_reg
    import rxc_pkg::*;
#(
    parameter int W = MODE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         protect,
    output logic [W-1:0] value_q
);

    logic [W-1:0] value_d;

    always_comb begin
        value_d = value_q;
        if (wr && !protect) begin
            value_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
        end else begin
            value_q <= value_d;
        end
    end

endmodule

// File: rtl/rxc_edge_gate.sv
module rxc_edge_gate
    import rxc_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  mode_t        mode,
    input  logic [N-1:0] rise_in,
    input  logic [N-1:0] fall_in,
    input  logic         fsync,
    output logic         rise_out,
    output logic         fall_out
);

    logic sel_rise;
    logic sel_fall;
    logic pass;

    always_comb begin
        sel_rise = 1'b0;
        sel_fall = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (int'(mode.src) == i) begin
                sel_rise = rise_in[i];
                sel_fall = fall_in[i];
            end
        end
    end

    always_comb begin
        unique case (mode.gate)
            GATE_LOW:  pass = !fsync;
            GATE_HIGH: pass = fsync;
            default:   pass = 1'b1;
        endcase
        rise_out = sel_rise && pass;
        fall_out = sel_fall && pass;
    end

endmodule

// File: rtl/rx_clk_ctrl.sv
module rx_clk_ctrl
    import rxc_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int CFG_W = MODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             wp_en,
    output logic [CFG_W-1:0] mode_q,
    input  logic [N_SRC-1:0] src_rise,
    input  logic [N_SRC-1:0] src_fall,
    input  logic             fsync,
    input  logic             xfer_active,
    output logic             sample_stb,
    output logic             launch_stb,
    output logic             pin_oe,
    output logic             pin_drive
);

    typedef struct packed {
        logic samp;
        logic launch;
        logic lvl;
        logic oe;
        logic drive;
    } st_t;

    st_t   st_d, st_q;
    mode_t mode;
    logic  g_rise;
    logic  g_fall;

    rxc_mode_reg #(.W(CFG_W)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .wdata   (cfg_data),
        .protect (wp_en),
        .value_q (mode_q)
    );

    assign mode = mode_t'(mode_q[MODE_W-1:0]);

    rxc_edge_gate #(.N(N_SRC)) u_gate (
        .mode     (mode),
        .rise_in  (src_rise),
        .fall_in  (src_fall),
        .fsync    (fsync),
        .rise_out (g_rise),
        .fall_out (g_fall)
    );

    always_comb begin
        st_d        = st_q;
        st_d.samp   = mode.inv ? g_rise : g_fall;
        st_d.launch = mode.inv ? g_fall : g_rise;
        if (g_rise) begin
            st_d.lvl = 1'b1;
        end else if (g_fall) begin
            st_d.lvl = 1'b0;
        end
        unique case (mode.pmode)
            PIN_CONT: st_d.oe = 1'b1;
            PIN_XFER: begin
                if (xfer_active) begin
                    st_d.oe = 1'b1;
                end else if (g_rise || g_fall) begin
                    st_d.oe = 1'b0;
                end
            end
            default:  st_d.oe = 1'b0;
        endcase
        st_d.drive = st_d.oe && st_d.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_stb = st_q.samp;
    assign launch_stb = st_q.launch;
    assign pin_oe     = st_q.oe;
    assign pin_drive  = st_q.drive;

endmodule

module rx_clk_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic       wp_en,
    input logic [7:0] mode_q,
    input logic       fsync,
    input logic       xfer_active,
    input logic       sample_stb,
    input logic       launch_stb,
    input logic       pin_oe,
    input logic       pin_drive
);

    assert_wp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && wp_en) |=> $stable(mode_q));

    assert_rsvd_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1:0] == 2'd3) |=> (!sample_stb && !launch_stb));

    assert_gate_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[7:6] == 2'd1 && fsync) |=> (!sample_stb && !launch_stb));

    assert_gate_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[7:6] == 2'd2 && !fsync) |=> (!sample_stb && !launch_stb));

    assert_pin_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[4:2] == 3'd0 || mode_q[4:2] >= 3'd3) |=> (!pin_oe && !pin_drive));

    assert_cont_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[4:2] == 3'd1) |=> pin_oe);

    assert_xfer_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[4:2] == 3'd2 && xfer_active) |=> pin_oe);

    assert_drive_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pin_drive |-> pin_oe);

endmodule

bind rx_clk_ctrl rx_clk_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .wp_en       (wp_en),
    .mode_q      (mode_q),
    .fsync       (fsync),
    .xfer_active (xfer_active),
    .sample_stb  (sample_stb),
    .launch_stb  (launch_stb),
    .pin_oe      (pin_oe),
    .pin_drive   (pin_drive)
);

// File: tb/rx_clk_ctrl_test.sv
module rx_clk_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_data = '0;
    logic       wp_en = 1'b0;
    logic [7:0] mode_q;
    logic [2:0] src_rise = '0;
    logic [2:0] src_fall = '0;
    logic       fsync = 1'b0;
    logic       xfer_active = 1'b0;
    logic       sample_stb, launch_stb, pin_oe, pin_drive;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    string cur_req = "R1";

    logic [7:0] m_mode = '0;
    bit m_samp = 0, m_launch = 0, m_lvl = 0, m_oe = 0, m_drive = 0;

    always #2 clk = ~clk;

    rx_clk_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_data    (cfg_data),
        .wp_en       (wp_en),
        .mode_q      (mode_q),
        .src_rise    (src_rise),
        .src_fall    (src_fall),
        .fsync       (fsync),
        .xfer_active (xfer_active),
        .sample_stb  (sample_stb),
        .launch_stb  (launch_stb),
        .pin_oe      (pin_oe),
        .pin_drive   (pin_drive)
    );

    task automatic check(string what, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic model_step(bit wr, logic [7:0] wd, bit wp, logic [2:0] rr,
                              logic [2:0] ff, bit fs, bit xa);
        int  sel = int'(m_mode[1:0]);
        bit  r = 0, f = 0, pass;
        case (m_mode[7:6])
            2'd1:    pass = !fs;
            2'd2:    pass = fs;
            default: pass = 1;
        endcase
        if (sel < 3) begin
            r = rr[sel] && pass;
            f = ff[sel] && pass;
        end
        m_samp   = m_mode[5] ? r : f;
        m_launch = m_mode[5] ? f : r;
        if (r) m_lvl = 1;
        else if (f) m_lvl = 0;
        case (m_mode[4:2])
            3'd1: m_oe = 1;
            3'd2: m_oe = xa ? 1 : ((r || f) ? 0 : m_oe);
            default: m_oe = 0;
        endcase
        m_drive = m_oe && m_lvl;
        if (wr && !wp) m_mode = wd;
    endtask

    task automatic step(bit wr, logic [7:0] wd, bit wp, logic [2:0] rr,
                        logic [2:0] ff, bit fs, bit xa);
        @(negedge clk);
        cfg_wr = wr; cfg_data = wd; wp_en = wp;
        src_rise = rr; src_fall = ff; fsync = fs; xfer_active = xa;
        @(posedge clk);
        #1;
        model_step(wr, wd, wp, rr, ff, fs, xa);
        check("mode_q", mode_q, m_mode);
        check("sample_stb", {7'd0, sample_stb}, {7'd0, m_samp});
        check("launch_stb", {7'd0, launch_stb}, {7'd0, m_launch});
        check("pin_oe", {7'd0, pin_oe}, {7'd0, m_oe});
        check("pin_drive", {7'd0, pin_drive}, {7'd0, m_drive});
    endtask

    task automatic idle(int n, bit fs = 0, bit xa = 0);
        for (int i = 0; i < n; i++) step(0, 8'h00, 0, 3'b000, 3'b000, fs, xa);
    endtask

    task automatic wr_mode(logic [7:0] v);
        step(1, v, 0, 3'b000, 3'b000, fsync, xfer_active);
    endtask

    task automatic edges(logic [2:0] mask, bit fs = 0, bit xa = 0);
        step(0, 8'h00, 0, mask, 3'b000, fs, xa);
        step(0, 8'h00, 0, 3'b000, 3'b000, fs, xa);
        step(0, 8'h00, 0, 3'b000, mask, fs, xa);
        step(0, 8'h00, 0, 3'b000, 3'b000, fs, xa);
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        check("mode_q in reset", mode_q, 8'h00);
        check("sample_stb in reset", {7'd0, sample_stb}, 8'h00);
        check("pin_oe in reset", {7'd0, pin_oe}, 8'h00);
        check("pin_drive in reset", {7'd0, pin_drive}, 8'h00);
        rst_n = 1'b1;
        idle(2);

        cur_req = "R2";
        wr_mode(8'h21);
        step(1, 8'h5A, 1, 3'b000, 3'b000, 0, 0);
        check("mode_q after protected write", mode_q, 8'h21);
        step(1, 8'h00, 0, 3'b000, 3'b000, 0, 0);
        check("mode_q after open write", mode_q, 8'h00);

        cur_req = "R3";
        for (int s = 0; s < 4; s++) begin
            wr_mode(8'(s));
            edges(3'b001);
            edges(3'b010);
            edges(3'b100);
        end

        cur_req = "R4";
        wr_mode(8'h01);
        edges(3'b010);
        edges(3'b111);

        cur_req = "R5";
        wr_mode(8'h22);
        edges(3'b100);
        edges(3'b011);

        cur_req = "R6";
        for (int g = 0; g < 4; g++) begin
            wr_mode(8'((g << 6) | 8'h04));
            edges(3'b001, 0);
            edges(3'b001, 1);
            step(0, 8'h00, 0, 3'b001, 3'b000, 1, 0);
            step(0, 8'h00, 0, 3'b000, 3'b001, 0, 0);
            idle(1);
        end

        cur_req = "R7";
        for (int p = 0; p < 8; p++) begin
            if (p == 1 || p == 2) continue;
            wr_mode(8'(p << 2));
            step(0, 8'h00, 0, 3'b001, 3'b000, 0, 1);
            idle(2, 0, 1);
        end

        cur_req = "R8";
        wr_mode(8'h04);
        edges(3'b001);
        wr_mode(8'h24);
        edges(3'b001);

        cur_req = "R9";
        wr_mode(8'h48);
        idle(2);
        step(0, 8'h00, 0, 3'b000, 3'b000, 0, 1);
        edges(3'b001, 0, 1);
        step(0, 8'h00, 0, 3'b001, 3'b000, 0, 1);
        idle(3);
        step(0, 8'h00, 0, 3'b000, 3'b001, 1, 0);
        step(0, 8'h00, 0, 3'b001, 3'b000, 1, 0);
        idle(2, 1, 0);
        check("pin_oe held while gate closed", {7'd0, pin_oe}, 8'h01);
        step(0, 8'h00, 0, 3'b000, 3'b001, 0, 0);
        idle(2);
        check("pin_oe released after passed edge", {7'd0, pin_oe}, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule